// File: doc/BRIEF.md
# Multi-pattern PRBS generator and checker

This block is a link test engine. Every clock it puts one 32-bit word of a chosen test pattern on its transmit output. It also compares a returning word stream against the same pattern. Four pseudo-random sequences of different lengths are available, and so are two fixed clock-like patterns: a fast alternating one and a slow square wave.

The checker needs no seed from outside. It locks onto whatever stream arrives by predicting each word from the words before it. Once locked, it counts every word that differs from the prediction. A test can corrupt single transmit words on request to prove that the whole loop sees errors. The number of corrupted words and the number of detected errors are kept in separate counters, and one clear command empties both.

The received stream is qualified by the run enable delayed by one clock. This matches a loopback path with one register of latency, such as the transmit register of this block wired straight back to its receive input.

Top module: `prbs_pattern_engine`

## Requirements
- R1: With `pat_sel` 0, 1, 2 or 3, `tx_data` carries PRBS of order 7, 15, 23 or 31 from the polynomials x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. Each shift register is a Fibonacci register, and its new bit is the XOR of the state bits at the two tap positions. It is seeded with all ones after reset or after a selection change. It advances 32 steps per word, and the earliest bit is placed in bit 31.
- R2: With `pat_sel` 4, and likewise with the unused codes 6 and 7, every transmitted word is 32'hAAAA_AAAA.
- R3: With `pat_sel` 5, the transmitted bit stream is 33 ones followed by 33 zeros, repeating. It is packed with the earliest bit in bit 31 and starts with the ones after a restart.
- R4: While `run_en` is low, `tx_data` is zero one clock later and the generator holds its place. When `run_en` returns high, the sequence resumes from the word that follows the last one sent.
- R5: An `insert_req` sampled while `run_en` is high inverts bit 0 of the word sent on that clock and adds one to `ins_errs`. An `insert_req` while `run_en` is low changes neither `ins_errs` nor the stream.
- R6: `in_sync` rises after 4 consecutive received words that each match the word predicted from the stream before them. For the PRBS codes, a prediction made from an all-zero register state never counts as a match, so a dead all-zero input never locks.
- R7: While in sync, each received word that differs from the expected word adds one to `det_errs`. The expected sequence then keeps running from its own state. Eight consecutive differing words drop `in_sync`, and seven do not.
- R8: `clear_req` sets both counters to zero on the next clock. It takes priority over an increment on the same clock.
- R9: Both counters stop at their all-ones value instead of wrapping.
- R10: A change of `pat_sel` drops `in_sync` on the next clock and restarts the generator from the seed of the new pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_sel | input | 3 | Pattern code: 0..3 PRBS orders, 4 alternating, 5 square wave |
| run_en | input | 1 | Test run enable |
| insert_req | input | 1 | Corrupt the current transmit word (one clock per request) |
| clear_req | input | 1 | Zero both error counters |
| tx_data | output | 32 | Transmit pattern word |
| rx_data | input | 32 | Received word stream |
| in_sync | output | 1 | Checker locked to the received stream |
| det_errs | output | CNT_W | Detected error word count |
| ins_errs | output | CNT_W | Inserted error word count |

## Verification
Some rules are checked on every cycle by the assertions. The counters move by at most one per clock, zero after a clear and hold at saturation. The transmit word is zero while stopped, and the alternating word differs from its constant only in an inserted bit 0. Lock is lost only after a selection change or after the eighth consecutive bad word. Other behaviour shows only in the bench's loopback scenarios: the exact bit order of every sequence across many words, the continuation after a pause, the seven-versus-eight boundary, the refusal to lock on an all-zero stream, and the exact error counts after inserts and injected receive faults.

// File: rtl/prbs_pat_pkg.sv
// Shared constants and pattern math for the PRBS test engine.
// Assumes a fixed 32-bit word. The history kept per stream is 33 bits:
// the latest word plus one older bit, which is what the square wave needs.
package prbs_pat_pkg;

    localparam int WORD_W = 32;
    localparam int HIST_W = WORD_W + 1;

    localparam logic [2:0] PAT_P7  = 3'd0;
    localparam logic [2:0] PAT_P15 = 3'd1;
    localparam logic [2:0] PAT_P23 = 3'd2;
    localparam logic [2:0] PAT_P31 = 3'd3;
    localparam logic [2:0] PAT_HF  = 3'd4;
    localparam logic [2:0] PAT_LF  = 3'd5;

    localparam logic [WORD_W-1:0] HF_WORD = 32'hAAAA_AAAA;

    // True for the four pseudo-random codes
    function automatic logic is_prbs(input logic [2:0] sel);
        return (sel[2] == 1'b0);
    endfunction

    // History to load on restart: all ones for the shift registers,
    // all zeros for the square wave so that it begins with the ones
    function automatic logic [HIST_W-1:0] seed_hist(input logic [2:0] sel);
        return (sel == PAT_LF) ? '0 : '1;
    endfunction

    // False when a shift register state is all zero and so predicts nothing
    function automatic logic live_state(input logic [2:0] sel, input logic [HIST_W-1:0] h);
        logic ok;
        case (sel)
            PAT_P7:  ok = |h[6:0];
            PAT_P15: ok = |h[14:0];
            PAT_P23: ok = |h[22:0];
            PAT_P31: ok = |h[30:0];
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

    // Next word of the selected pattern, computed from the stream history.
    // h[0] is the most recent bit; the earliest bit of the result goes in bit 31.
    function automatic logic [WORD_W-1:0] next_word(input logic [2:0] sel,
                                                    input logic [HIST_W-1:0] h);
        logic [WORD_W-1:0] w;
        logic [30:0]       s;
        logic [4:0]        tn;
        logic [4:0]        tm;
        logic              nb;
        w  = '0;
        s  = h[30:0];
        tn = 5'd7;
        tm = 5'd6;
        case (sel)
            PAT_P15: begin tn = 5'd15; tm = 5'd14; end
            PAT_P23: begin tn = 5'd23; tm = 5'd18; end
            PAT_P31: begin tn = 5'd31; tm = 5'd28; end
            default: ;
        endcase
        if (is_prbs(sel)) begin
            for (int i = 0; i < WORD_W; i++) begin
                nb = s[tn - 5'd1] ^ s[tm - 5'd1];
                s  = {s[29:0], nb};
                w[WORD_W-1-i] = nb;
            end
        end else if (sel == PAT_LF) begin
            // each bit is the inverse of the bit 33 places earlier
            for (int k = 0; k < WORD_W; k++) begin
                w[k] = ~h[k+1];
            end
        end else begin
            w = HF_WORD;
        end
        return w;
    endfunction

endpackage

// File: rtl/sat_err_counter.sv
// Saturating event counter with a synchronous clear.
// Assumes at most one event per clock. Clear wins over an event on the same clock.
module sat_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events, stop at all ones, zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == CNT_MAX) |=> (count == CNT_MAX));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/prbs_tx_gen.sv
// Transmit side: produces one pattern word per clock while running.
// Assumes restart is a one-clock pulse raised when the pattern code changes.
// An insert request while running inverts bit 0 of the outgoing word.
module prbs_tx_gen
    import prbs_pat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pat_sel,
    input  logic              restart,
    input  logic              run,
    input  logic              insert_req,
    output logic [WORD_W-1:0] tx_data
);

    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] hist_base;
    logic [WORD_W-1:0] pred;

    // Pick the starting history: the fresh seed on restart, else the stored one
    always_comb begin
        hist_base = restart ? seed_hist(pat_sel) : hist;
        pred      = next_word(pat_sel, hist_base);
    end

    // Advance the pattern and register the outgoing word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= seed_hist(pat_sel);
            tx_data <= '0;
        end else if (run) begin
            hist    <= {hist_base[0], pred};
            tx_data <= pred ^ {{(WORD_W-1){1'b0}}, insert_req};
        end else begin
            hist    <= hist_base;
            tx_data <= '0;
        end
    end

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tx_data == '0));

    // R2
    hf_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pat_sel == PAT_HF) |=>
            (tx_data == (HF_WORD ^ {{(WORD_W-1){1'b0}}, $past(insert_req)})));

endmodule

// File: rtl/prbs_rx_chk.sv
// Receive side: self-seeding pattern checker with lock tracking.
// Before lock, each word is predicted from the received history, and
// SYNC_GOOD matches in a row give lock. After lock, the expected stream runs
// on its own and SYNC_LOSS mismatches in a row drop lock.
// Assumes en marks the clocks that carry a valid received word.
module prbs_rx_chk
    import prbs_pat_pkg::*;
#(
    parameter int SYNC_GOOD = 4,
    parameter int SYNC_LOSS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pat_sel,
    input  logic              restart,
    input  logic              en,
    input  logic [WORD_W-1:0] rx_data,
    output logic              in_sync,
    output logic              err_hit
);

    localparam int GOOD_W = $clog2(SYNC_GOOD + 1);
    localparam int LOSS_W = $clog2(SYNC_LOSS + 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(SYNC_GOOD - 1);
    localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(SYNC_LOSS - 1);

    logic [HIST_W-1:0] hist;
    logic [GOOD_W-1:0] good_cnt;
    logic [LOSS_W-1:0] bad_cnt;
    logic              sync_q;
    logic [WORD_W-1:0] exp_w;
    logic              differ;
    logic              match;

    // Predict the current word and compare
    always_comb begin
        exp_w   = next_word(pat_sel, hist);
        differ  = (rx_data != exp_w);
        match   = !differ && live_state(pat_sel, hist);
        err_hit = en && sync_q && !restart && differ;
    end

    // Track history and the lock state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist     <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
            sync_q   <= 1'b0;
        end else if (restart) begin
            hist     <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
            sync_q   <= 1'b0;
        end else if (en) begin
            if (sync_q) begin
                hist <= {hist[0], exp_w};
                if (differ) begin
                    if (bad_cnt == LOSS_LAST) begin
                        sync_q   <= 1'b0;
                        bad_cnt  <= '0;
                        good_cnt <= '0;
                    end else begin
                        bad_cnt <= bad_cnt + 1'b1;
                    end
                end else begin
                    bad_cnt <= '0;
                end
            end else begin
                hist <= {hist[0], rx_data};
                if (match) begin
                    if (good_cnt == GOOD_LAST) begin
                        sync_q   <= 1'b1;
                        good_cnt <= '0;
                        bad_cnt  <= '0;
                    end else begin
                        good_cnt <= good_cnt + 1'b1;
                    end
                end else begin
                    good_cnt <= '0;
                end
            end
        end
    end

    assign in_sync = sync_q;

    // R10
    restart_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !in_sync);

    // R6
    lock_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(en && !restart && match));

    // R7
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sync) |-> ($past(restart) || $past(bad_cnt) == LOSS_LAST));

endmodule

// File: rtl/prbs_pattern_engine.sv
// Top of the PRBS test engine: generator, self-seeding checker and the
// inserted/detected error counters. The receive stream is qualified by
// run_en delayed one clock, matching a single-register loopback.
module prbs_pattern_engine
    import prbs_pat_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_GOOD = 4,
    parameter int SYNC_LOSS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pat_sel,
    input  logic              run_en,
    input  logic              insert_req,
    input  logic              clear_req,
    output logic [WORD_W-1:0] tx_data,
    input  logic [WORD_W-1:0] rx_data,
    output logic              in_sync,
    output logic [CNT_W-1:0]  det_errs,
    output logic [CNT_W-1:0]  ins_errs
);

    logic [2:0] sel_q;
    logic       run_q;
    logic       restart;
    logic       err_hit;
    logic       ins_take;

    // Remember the last code and the run state for change and qualify logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= pat_sel;
            run_q <= 1'b0;
        end else begin
            sel_q <= pat_sel;
            run_q <= run_en;
        end
    end

    // Derive the restart pulse and accepted inserts
    always_comb begin
        restart  = (pat_sel != sel_q);
        ins_take = insert_req && run_en;
    end

    prbs_tx_gen u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_sel    (pat_sel),
        .restart    (restart),
        .run        (run_en),
        .insert_req (insert_req),
        .tx_data    (tx_data)
    );

    prbs_rx_chk #(
        .SYNC_GOOD (SYNC_GOOD),
        .SYNC_LOSS (SYNC_LOSS)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pat_sel (pat_sel),
        .restart (restart),
        .en      (run_q),
        .rx_data (rx_data),
        .in_sync (in_sync),
        .err_hit (err_hit)
    );

    sat_err_counter #(.CNT_W(CNT_W)) u_det_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_req),
        .inc   (err_hit),
        .count (det_errs)
    );

    sat_err_counter #(.CNT_W(CNT_W)) u_ins_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_req),
        .inc   (ins_take),
        .count (ins_errs)
    );

    // R5
    ins_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clear_req) |=> $stable(ins_errs));

endmodule

// File: tb/tb_prbs_pattern_engine.sv
// Loopback scoreboard bench: the driver pushes the expected transmit word for
// every running cycle and a monitor pops and compares just after each edge.
module tb_prbs_pattern_engine;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    pat_sel;
    logic          run_en;
    logic          insert_req;
    logic          clear_req;
    logic [31:0]   tx_data;
    logic [31:0]   rx_data;
    logic [31:0]   flip;
    logic          rzero;
    logic          in_sync;
    logic [CW-1:0] det_errs;
    logic [CW-1:0] ins_errs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // independent reference model state
    logic [30:0] bst;
    int          bph;
    logic [2:0]  bpat;

    always #5 clk = ~clk;

    assign rx_data = rzero ? 32'h0 : (tx_data ^ flip);

    prbs_pattern_engine #(.CNT_W(CW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_sel    (pat_sel),
        .run_en     (run_en),
        .insert_req (insert_req),
        .clear_req  (clear_req),
        .tx_data    (tx_data),
        .rx_data    (rx_data),
        .in_sync    (in_sync),
        .det_errs   (det_errs),
        .ins_errs   (ins_errs)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic model_reset(input logic [2:0] p);
        bpat = p;
        bst  = '1;
        bph  = 0;
    endtask

    // Produce the next expected word, bit by bit, straight from R1..R3
    task automatic model_word(output logic [31:0] w);
        int tn;
        int tm;
        logic nb;
        w = '0;
        tn = 7; tm = 6;
        if (bpat == 3'd1) begin tn = 15; tm = 14; end
        if (bpat == 3'd2) begin tn = 23; tm = 18; end
        if (bpat == 3'd3) begin tn = 31; tm = 28; end
        if (bpat <= 3'd3) begin
            for (int i = 0; i < 32; i++) begin
                nb  = bst[tn-1] ^ bst[tm-1];
                bst = {bst[29:0], nb};
                w[31-i] = nb;
            end
        end else if (bpat == 3'd5) begin
            for (int i = 0; i < 32; i++) begin
                w[31-i] = (bph < 33);
                bph = (bph + 1) % 66;
            end
        end else begin
            w = 32'hAAAA_AAAA;
        end
    endtask

    // Driver: one clock of stimulus, pushing the expected word when running
    task automatic cyc(input logic r, input logic [2:0] p, input logic ins,
                       input logic clr, input logic [31:0] fl);
        logic [31:0] w;
        string t;
        @(negedge clk);
        if (p != pat_sel) model_reset(p);
        pat_sel    = p;
        run_en     = r;
        insert_req = ins;
        clear_req  = clr;
        flip       = fl;
        if (r) begin
            model_word(w);
            if (ins) t = "R5 insert word";
            else if (p <= 3'd3) t = "R1 prbs word";
            else if (p == 3'd5) t = "R3 square word";
            else t = "R2 alternating word";
            exp_q.push_back(w ^ {31'b0, ins});
            tag_q.push_back(t);
        end
    endtask

    task automatic run_n(input int n, input logic [2:0] p);
        for (int i = 0; i < n; i++) cyc(1'b1, p, 1'b0, 1'b0, 32'h0);
    endtask

    // Monitor: compare each produced word with the scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && run_en && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(tx_data == e, t, tx_data, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; pat_sel = 3'd0; insert_req = 1'b0;
        clear_req = 1'b0; flip = '0; rzero = 1'b0;
        model_reset(3'd0);
        repeat (3) @(negedge clk);
        chk(tx_data == 0, "R4 reset tx", tx_data, 0);
        chk(in_sync == 0, "R6 reset sync", {31'b0, in_sync}, 0);
        chk(det_errs == 0 && ins_errs == 0, "R8 reset counters", {det_errs, ins_errs}, 0);
        rst_n = 1'b1;

        // every pattern in turn, with lock loss on each change
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 80; i++) begin
                cyc(1'b1, 3'(p), 1'b0, 1'b0, 32'h0);
                if (i == 1 && p > 0)
                    chk(in_sync == 0, "R10 unlock on change", {31'b0, in_sync}, 0);
            end
            chk(in_sync == 1, "R6 lock on clean stream", {31'b0, in_sync}, 1);
            chk(det_errs == 0, "R7 no errors on clean stream", {28'b0, det_errs}, 0);
        end
        run_n(10, 3'd7);
        chk(in_sync == 1, "R2 unused code locks as alternating", {31'b0, in_sync}, 1);

        // pause and resume
        run_n(40, 3'd3);
        cyc(1'b0, 3'd3, 1'b0, 1'b0, 32'h0);
        cyc(1'b0, 3'd3, 1'b0, 1'b0, 32'h0);
        chk(tx_data == 0, "R4 idle word zero", tx_data, 0);
        repeat (3) cyc(1'b0, 3'd3, 1'b0, 1'b0, 32'h0);
        run_n(10, 3'd3);
        chk(in_sync == 1 && det_errs == 0, "R4 resume keeps lock",
            {27'b0, det_errs, in_sync}, 1);

        // spaced inserts
        for (int k = 0; k < 5; k++) begin
            cyc(1'b1, 3'd3, 1'b1, 1'b0, 32'h0);
            cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h0);
        end
        run_n(3, 3'd3);
        chk(ins_errs == 5, "R5 inserted count", {28'b0, ins_errs}, 5);
        chk(det_errs == 5, "R5 detected inserts", {28'b0, det_errs}, 5);
        cyc(1'b0, 3'd3, 1'b1, 1'b0, 32'h0);
        run_n(3, 3'd3);
        chk(ins_errs == 5, "R5 insert ignored while stopped", {28'b0, ins_errs}, 5);

        // clear against a same-clock insert
        cyc(1'b1, 3'd3, 1'b1, 1'b1, 32'h0);
        cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h0);
        chk(ins_errs == 0, "R8 clear beats insert", {28'b0, ins_errs}, 0);
        run_n(3, 3'd3);
        chk(det_errs == 1, "R8 counting resumes after clear", {28'b0, det_errs}, 1);
        cyc(1'b1, 3'd3, 1'b0, 1'b1, 32'h0);
        cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h0);
        chk(det_errs == 0 && ins_errs == 0, "R8 clear both", {det_errs, ins_errs}, 0);

        // receive faults: seven keep lock, eight drop it
        for (int i = 0; i < 7; i++) cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h1);
        cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h0);
        chk(in_sync == 1, "R7 seven bad words keep lock", {31'b0, in_sync}, 1);
        chk(det_errs == 7, "R7 one count per bad word", {28'b0, det_errs}, 7);
        for (int i = 0; i < 8; i++) cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h8000_0000);
        cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h0);
        chk(in_sync == 0, "R7 eight bad words drop lock", {31'b0, in_sync}, 0);
        chk(det_errs == 15, "R7 count reaches top", {28'b0, det_errs}, 15);
        run_n(12, 3'd3);
        chk(in_sync == 1, "R6 relock after faults", {31'b0, in_sync}, 1);

        // saturation
        for (int k = 0; k < 20; k++) begin
            cyc(1'b1, 3'd3, 1'b1, 1'b0, 32'h0);
            cyc(1'b1, 3'd3, 1'b0, 1'b0, 32'h0);
        end
        run_n(3, 3'd3);
        chk(ins_errs == 15, "R9 inserted count saturates", {28'b0, ins_errs}, 15);
        chk(det_errs == 15, "R9 detected count saturates", {28'b0, det_errs}, 15);

        // dead all-zero input must not lock
        rzero = 1'b1;
        run_n(12, 3'd0);
        chk(in_sync == 0, "R6 zero stream never locks", {31'b0, in_sync}, 0);
        @(negedge clk);
        rzero = 1'b0;
        exp_q.push_back(32'h0);
        tag_q.push_back("R1 prbs word");
        begin
            logic [31:0] w;
            model_word(w);
            exp_q.pop_back();
            exp_q.push_back(w);
        end
        run_n(12, 3'd0);
        chk(in_sync == 1, "R6 lock after zero stream ends", {31'b0, in_sync}, 1);

        run_n(2, 3'd0);
        cyc(1'b0, 3'd0, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule